// File: doc/BRIEF.md
# Entropy Mixer Block Assembler

This block sits between a set of entropy sources and a random generator. It takes 32-bit words from several independent sources in strict turn and packs them into 1024-bit message blocks. It hands each full block to an external hash engine over a start/ready/digest-valid handshake. Each block comes back as a 512-bit digest. Two digests make up one reseed. The block runs two mixing rounds in a row and then presents the seed with a single-cycle valid strobe. The seed is split into a 512-bit block field, a 256-bit key, a 64-bit IV and a 64-bit counter.

After reset the block is idle and waits for the generator to ask for seed material. Each request starts a fresh two-round sequence. A source can be taken out of the rotation by lowering its enable or raising its error flag. While the hash engine works on a block, no words are taken, so every word feeds exactly one block.

Top module: `entropy_mixer`

## Requirements
- R1: After reset no source is acknowledged, `hash_start` and `seed_valid` stay low and all seed outputs read zero until `seed_more` is seen.
- R2: A source is healthy when its enable is high and its error flag is low. The block serves healthy sources in rotating order, starting with the next healthy index after the last one served (index 0 first after reset). It waits for the selected source's `src_valid` rather than passing over it. At most one acknowledge is high per cycle, and only together with that source's `src_valid`.
- R3: A source whose enable is low or whose error flag is high is never acknowledged.
- R4: A block holds 32 words. The k-th accepted word (k = 0..31) sits in `hash_block[1023-32k -: 32]`, so the first word occupies bits 1023:992.
- R5: `hash_start` is high for one cycle per block, only while `hash_ready` is high, and only once all 32 words are in.
- R6: No word is taken from a full block until its digest returns. The next block is built from 32 new words, so exactly 32 acknowledges separate two `hash_start` pulses.
- R7: The first digest of a sequence becomes `seed_block`. Of the second digest, bits 511:256 become `seed_key`, bits 255:192 `seed_iv` and bits 191:128 `seed_ctr`. Bits 127:0 are discarded.
- R8: `seed_valid` is high for exactly one cycle, the cycle after the second digest's `hash_digest_valid`.
- R9: After a seed is delivered the block takes no words and starts no hash until `seed_more`. A `seed_more` that arrives while a sequence is running is ignored.
- R10: Seed outputs hold their value except at the delivery of a new seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_en | input | N_SRC | Per-source enable |
| src_err | input | N_SRC | Per-source health error flag |
| src_valid | input | N_SRC | Per-source word available |
| src_data | input | N_SRC*32 | Source words, source i in bits 32i+31:32i |
| src_ack | output | N_SRC | Word taken from source i this cycle |
| hash_ready | input | 1 | Hash engine can accept a block |
| hash_start | output | 1 | Hash the block on `hash_block` |
| hash_block | output | 1024 | Assembled message block |
| hash_digest_valid | input | 1 | Digest present on `hash_digest` |
| hash_digest | input | 512 | Hash result |
| seed_more | input | 1 | Generator requests a new seed |
| seed_valid | output | 1 | Seed fields valid this cycle |
| seed_block | output | 512 | Seed block field |
| seed_key | output | 256 | Seed key field |
| seed_iv | output | 64 | Seed IV field |
| seed_ctr | output | 64 | Seed counter field |

## Verification
The bench disables one source and, in a separate run, flags another with an error. A design that still served them would place their tagged words in the block, and a design that handled the rotation pointer wrongly would place words in the wrong slots. One source's valid is toggled while the others stay ready. A design that skipped a non-ready source would then break the expected strict order. The hash engine is held not-ready after a block fills, which catches a design that keeps taking words and would show extra acknowledges. A second `seed_more` is issued mid-sequence, which catches a design that restarts and would consume more than 64 words for one seed. The delivered seed is compared field by field against digests of blocks the bench predicts, which exposes any swapped or shifted field.

// File: rtl/mixer_pkg.sv
// Shared types for the entropy mixer.
package mixer_pkg;
    // Sequencer states: idle, block fill, hash request, digest wait, seed strobe.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_HASH_REQ,
        ST_HASH_WAIT,
        ST_SEED_OUT
    } mix_state_t;
endpackage

// File: rtl/mixer_rr_picker.sv
// Rotating source selector.
// Picks the first healthy source at or after the rotation pointer. It takes a
// word only when that source has data, so it waits rather than passing over a
// healthy source that is not ready. Assumes N_SRC >= 2.
module mixer_rr_picker #(
    parameter int N_SRC = 2,
    localparam int PTR_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [N_SRC-1:0] healthy,
    input  logic [N_SRC-1:0] valid,
    output logic [N_SRC-1:0] grant,
    output logic             take
);
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] cand;
    logic             found;

    // Search healthy sources in rotation order from the pointer.
    always_comb begin
        cand  = '0;
        found = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            int idx;
            idx = (int'(ptr_q) + i) % N_SRC;
            if (!found && healthy[idx]) begin
                found = 1'b1;
                cand  = PTR_W'(idx);
            end
        end
    end

    // Grant the candidate only when collecting and its word is present.
    always_comb begin
        take  = enable && found && valid[cand];
        grant = '0;
        if (take) grant[cand] = 1'b1;
    end

    // Advance the pointer past the source just served.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (take)
            ptr_q <= (int'(cand) == N_SRC - 1) ? '0 : cand + 1'b1;
    end
endmodule

// File: rtl/mixer_block_packer.sv
// Message block assembler.
// Places successive words from the most significant slot downwards and flags
// the block full after BLOCK_WORDS words. Assumes take is never high when full.
module mixer_block_packer #(
    parameter int WORD_W      = 32,
    parameter int BLOCK_WORDS = 32,
    localparam int BLOCK_W = WORD_W * BLOCK_WORDS,
    localparam int CNT_W   = $clog2(BLOCK_WORDS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               take,
    input  logic [WORD_W-1:0]  word,
    output logic [BLOCK_W-1:0] block,
    output logic               full
);
    logic [CNT_W-1:0] cnt_q;

    // Count accepted words; restart at the beginning of each block.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (take)
            cnt_q <= cnt_q + 1'b1;
    end

    // One register slot per word position; slot 0 is the top of the block.
    for (genvar g = 0; g < BLOCK_WORDS; g++) begin : g_slot
        // Load this slot when the word count points at it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                block[BLOCK_W-1-g*WORD_W -: WORD_W] <= '0;
            else if (take && !clear && cnt_q == CNT_W'(g))
                block[BLOCK_W-1-g*WORD_W -: WORD_W] <= word;
        end
    end

    assign full = (cnt_q == CNT_W'(BLOCK_WORDS));
endmodule

// File: rtl/mixer_seed_seq.sv
// Two-round reseed sequencer.
// Starts a sequence on a seed request, asks for a hash when the block is full,
// keeps the first digest and builds the seed fields from both digests, then
// strobes seed_valid once. Assumes the hash engine answers each start once.
module mixer_seed_seq
    import mixer_pkg::*;
#(
    parameter int DIGEST_W = 512,
    parameter int KEY_W    = 256,
    parameter int IV_W     = 64,
    parameter int CTR_W    = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                full,
    input  logic                hash_ready,
    input  logic                digest_valid,
    input  logic [DIGEST_W-1:0] digest,
    input  logic                seed_more,
    output logic                collect_en,
    output logic                pack_clear,
    output logic                hash_start,
    output logic                seed_valid,
    output logic [DIGEST_W-1:0] seed_block,
    output logic [KEY_W-1:0]    seed_key,
    output logic [IV_W-1:0]     seed_iv,
    output logic [CTR_W-1:0]    seed_ctr
);
    mix_state_t          state_q;
    logic                second_q;
    logic [DIGEST_W-1:0] dig0_q;
    logic                last_digest;

    assign last_digest = (state_q == ST_HASH_WAIT) && digest_valid && second_q;

    // Derive handshake and control strobes from the state.
    always_comb begin
        collect_en = (state_q == ST_COLLECT) && !full;
        hash_start = (state_q == ST_HASH_REQ) && hash_ready;
        seed_valid = (state_q == ST_SEED_OUT);
        pack_clear = ((state_q == ST_HASH_WAIT) && digest_valid)
                   || ((state_q == ST_IDLE) && seed_more);
    end

    // Step through the two mixing rounds of one reseed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            second_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (seed_more) begin
                    state_q  <= ST_COLLECT;
                    second_q <= 1'b0;
                end
                ST_COLLECT:   if (full) state_q <= ST_HASH_REQ;
                ST_HASH_REQ:  if (hash_ready) state_q <= ST_HASH_WAIT;
                ST_HASH_WAIT: if (digest_valid) begin
                    state_q  <= second_q ? ST_SEED_OUT : ST_COLLECT;
                    second_q <= 1'b1;
                end
                ST_SEED_OUT:  state_q <= ST_IDLE;
                default:      state_q <= ST_IDLE;
            endcase
        end
    end

    // Keep the first-round digest until the second round completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dig0_q <= '0;
        else if (state_q == ST_HASH_WAIT && digest_valid && !second_q)
            dig0_q <= digest;
    end

    // Load all seed fields together when the second digest arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_block <= '0;
            seed_key   <= '0;
            seed_iv    <= '0;
            seed_ctr   <= '0;
        end else if (last_digest) begin
            seed_block <= dig0_q;
            seed_key   <= digest[DIGEST_W-1 -: KEY_W];
            seed_iv    <= digest[DIGEST_W-KEY_W-1 -: IV_W];
            seed_ctr   <= digest[DIGEST_W-KEY_W-IV_W-1 -: CTR_W];
        end
    end
endmodule

// File: rtl/entropy_mixer.sv
// Entropy mixer top.
// Interleaves words from N_SRC sources into hash-sized blocks, drives the
// external hash handshake and delivers a wide seed built from two digests.
// Assumes src_data stays stable while src_valid is high and not acknowledged.
module entropy_mixer #(
    parameter int N_SRC       = 2,
    parameter int WORD_W      = 32,
    parameter int BLOCK_WORDS = 32,
    parameter int DIGEST_W    = 512,
    parameter int KEY_W       = 256,
    parameter int IV_W        = 64,
    parameter int CTR_W       = 64,
    localparam int BLOCK_W = WORD_W * BLOCK_WORDS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SRC-1:0]          src_en,
    input  logic [N_SRC-1:0]          src_err,
    input  logic [N_SRC-1:0]          src_valid,
    input  logic [N_SRC*WORD_W-1:0]   src_data,
    output logic [N_SRC-1:0]          src_ack,
    input  logic                      hash_ready,
    output logic                      hash_start,
    output logic [BLOCK_W-1:0]        hash_block,
    input  logic                      hash_digest_valid,
    input  logic [DIGEST_W-1:0]       hash_digest,
    input  logic                      seed_more,
    output logic                      seed_valid,
    output logic [DIGEST_W-1:0]       seed_block,
    output logic [KEY_W-1:0]          seed_key,
    output logic [IV_W-1:0]           seed_iv,
    output logic [CTR_W-1:0]          seed_ctr
);
    logic              collect_en;
    logic              pack_clear;
    logic              take;
    logic              full;
    logic [WORD_W-1:0] word_sel;
    logic [N_SRC-1:0]  healthy;

    assign healthy = src_en & ~src_err;

    mixer_rr_picker #(.N_SRC(N_SRC)) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (collect_en),
        .healthy(healthy),
        .valid  (src_valid),
        .grant  (src_ack),
        .take   (take)
    );

    // Route the granted source's word to the packer.
    always_comb begin
        word_sel = '0;
        for (int i = 0; i < N_SRC; i++)
            if (src_ack[i]) word_sel = word_sel | src_data[i*WORD_W +: WORD_W];
    end

    mixer_block_packer #(.WORD_W(WORD_W), .BLOCK_WORDS(BLOCK_WORDS)) u_pack (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(pack_clear),
        .take (take),
        .word (word_sel),
        .block(hash_block),
        .full (full)
    );

    mixer_seed_seq #(
        .DIGEST_W(DIGEST_W), .KEY_W(KEY_W), .IV_W(IV_W), .CTR_W(CTR_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .full        (full),
        .hash_ready  (hash_ready),
        .digest_valid(hash_digest_valid),
        .digest      (hash_digest),
        .seed_more   (seed_more),
        .collect_en  (collect_en),
        .pack_clear  (pack_clear),
        .hash_start  (hash_start),
        .seed_valid  (seed_valid),
        .seed_block  (seed_block),
        .seed_key    (seed_key),
        .seed_iv     (seed_iv),
        .seed_ctr    (seed_ctr)
    );
endmodule

// File: rtl/mixer_chk.sv
// Protocol checker for entropy_mixer, bound to every instance of it.
// Tracks busy/idle windows and words per block with its own counters.
module mixer_chk #(
    parameter int N_SRC       = 2,
    parameter int BLOCK_WORDS = 32,
    parameter int KEY_W       = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_en,
    input logic [N_SRC-1:0] src_err,
    input logic [N_SRC-1:0] src_valid,
    input logic [N_SRC-1:0] src_ack,
    input logic             hash_ready,
    input logic             hash_start,
    input logic             hash_digest_valid,
    input logic             seed_more,
    input logic             seed_valid,
    input logic [KEY_W-1:0] seed_key
);
    logic        busy_q;
    logic        idle_q;
    logic [15:0] acks_q;

    // Track the hash-in-progress window, the post-seed idle window and words per block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idle_q <= 1'b1;
            acks_q <= '0;
        end else begin
            if (hash_start) busy_q <= 1'b1;
            else if (hash_digest_valid) busy_q <= 1'b0;
            if (seed_valid) idle_q <= 1'b1;
            else if (seed_more) idle_q <= 1'b0;
            if (hash_start) acks_q <= '0;
            else acks_q <= acks_q + 16'($countones(src_ack));
        end
    end

    // R2
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_ack));
    // R2
    ack_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ack & ~src_valid) == '0);
    // R3
    ack_healthy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ack & ~(src_en & ~src_err)) == '0);
    // R5
    start_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hash_start |-> hash_ready);
    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hash_start |=> !hash_start);
    // R6
    busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (src_ack == '0));
    // R6
    block_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hash_start |-> (acks_q == 16'(BLOCK_WORDS)));
    // R8
    seed_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_valid |=> !seed_valid);
    // R8
    seed_after_digest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_valid |-> $past(hash_digest_valid));
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q |-> (src_ack == '0 && !hash_start));
    // R10
    seed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hash_digest_valid |=> $stable(seed_key));
endmodule

bind entropy_mixer mixer_chk #(
    .N_SRC(N_SRC), .BLOCK_WORDS(BLOCK_WORDS), .KEY_W(KEY_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .src_en           (src_en),
    .src_err          (src_err),
    .src_valid        (src_valid),
    .src_ack          (src_ack),
    .hash_ready       (hash_ready),
    .hash_start       (hash_start),
    .hash_digest_valid(hash_digest_valid),
    .seed_more        (seed_more),
    .seed_valid       (seed_valid),
    .seed_key         (seed_key)
);

// File: tb/entropy_mixer_test.sv
// Directed bench: three tagged counting sources, a delayed-answer hash stub.
module entropy_mixer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS  = 3;
    localparam int W   = 32;
    localparam int BWD = 32;
    localparam int BLK = W * BWD;
    localparam int DW  = 512;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NS-1:0]     src_en = '1, src_err = '0, src_valid = '1;
    logic [NS*W-1:0]   src_data;
    logic [NS-1:0]     src_ack;
    logic              hash_ready, hash_start, hash_digest_valid;
    logic [BLK-1:0]    hash_block;
    logic [DW-1:0]     hash_digest;
    logic              seed_more = 1'b0, seed_valid;
    logic [DW-1:0]     seed_block;
    logic [255:0]      seed_key;
    logic [63:0]       seed_iv, seed_ctr;

    int total = 0, bad = 0;

    entropy_mixer #(.N_SRC(NS)) uut (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .src_err(src_err),
        .src_valid(src_valid), .src_data(src_data), .src_ack(src_ack),
        .hash_ready(hash_ready), .hash_start(hash_start), .hash_block(hash_block),
        .hash_digest_valid(hash_digest_valid), .hash_digest(hash_digest),
        .seed_more(seed_more), .seed_valid(seed_valid), .seed_block(seed_block),
        .seed_key(seed_key), .seed_iv(seed_iv), .seed_ctr(seed_ctr)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    // Sources: word = {tag A0+i, 8'h00, running count}; count advances on acknowledge.
    logic [15:0] seq [NS];
    initial for (int i = 0; i < NS; i++) seq[i] = '0;
    for (genvar i = 0; i < NS; i++) begin : g_src
        assign src_data[i*W +: W] = {8'(160 + i), 8'h00, seq[i]};
    end
    int ack_total = 0;
    always @(posedge clk) begin
        for (int i = 0; i < NS; i++) if (src_ack[i]) seq[i] <= seq[i] + 1'b1;
        ack_total <= ack_total + $countones(src_ack);
    end

    function automatic logic [DW-1:0] fold(input logic [BLK-1:0] b);
        return b[BLK-1:DW] ^ b[DW-1:0] ^ {16{32'h5A5AC3C3}};
    endfunction

    // Hash stub: answers each start after a short delay; ready can be held low.
    logic          hold_ready = 1'b0, stub_busy = 1'b0, dv = 1'b0;
    int            dly = 0, ncap = 0, nseed = 0, sv_long = 0;
    logic          sv_prev = 1'b0;
    logic [BLK-1:0] cap [4];
    logic [DW-1:0] dig = '0;
    assign hash_ready = !stub_busy && !hold_ready;
    assign hash_digest_valid = dv;
    assign hash_digest = dig;
    always @(posedge clk) begin
        dv <= 1'b0;
        if (hash_start && !stub_busy) begin
            stub_busy <= 1'b1;
            dly <= 4;
            cap[ncap % 4] <= hash_block;
            dig <= fold(hash_block);
            ncap <= ncap + 1;
        end else if (stub_busy) begin
            if (dly == 0) begin dv <= 1'b1; stub_busy <= 1'b0; end
            else dly <= dly - 1;
        end
        if (seed_valid) nseed <= nseed + 1;
        if (seed_valid && sv_prev) sv_long <= sv_long + 1;
        sv_prev <= seed_valid;
    end

    task automatic check(input bit ok, input string req, input logic [BLK-1:0] act,
                         input logic [BLK-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bench model of the rotation and source counters.
    int mptr = 0;
    int mseq [NS];
    initial for (int i = 0; i < NS; i++) mseq[i] = 0;

    task automatic model_block(input logic [NS-1:0] hmask, output logic [BLK-1:0] b);
        b = '0;
        for (int k = 0; k < BWD; k++) begin
            int s = -1;
            for (int j = 0; j < NS; j++) begin
                int idx = (mptr + j) % NS;
                if (s < 0 && hmask[idx]) s = idx;
            end
            b[BLK-1-k*W -: W] = {8'(160 + s), 8'h00, 16'(mseq[s])};
            mseq[s]++;
            mptr = (s + 1) % NS;
        end
    endtask

    task automatic pulse_more();
        @(negedge clk) seed_more = 1'b1;
        @(negedge clk) seed_more = 1'b0;
    endtask

    // Wait for the next seed and compare blocks, seed fields, word count and strobe.
    task automatic finish_seed(input string tag, input int cap0, input int ack0,
                               input int seed0, input logic [NS-1:0] hmask);
        logic [BLK-1:0] b0, b1;
        logic [DW-1:0]  d1;
        int guard = 0;
        model_block(hmask, b0);
        model_block(hmask, b1);
        while (nseed == seed0 && guard < 5000) begin @(negedge clk); guard++; end
        check(guard < 5000, {"R8 seed timeout ", tag}, BLK'(nseed), BLK'(seed0 + 1));
        // R4 R2 R3: packing and order of both blocks
        check(cap[cap0 % 4] == b0, {"R4 block0 ", tag}, cap[cap0 % 4], b0);
        check(cap[(cap0 + 1) % 4] == b1, {"R2 block1 ", tag}, cap[(cap0 + 1) % 4], b1);
        d1 = fold(b1);
        // R7: field split
        check(seed_block == fold(b0), {"R7 block ", tag}, BLK'(seed_block), BLK'(fold(b0)));
        check({seed_key, seed_iv, seed_ctr} == d1[511:128], {"R7 key/iv/ctr ", tag},
              BLK'({seed_key, seed_iv, seed_ctr}), BLK'(d1[511:128]));
        // R6: exactly 64 words per seed
        check(ack_total - ack0 == 2 * BWD, {"R6 word count ", tag},
              BLK'(ack_total - ack0), BLK'(2 * BWD));
        // R8: single-cycle strobe
        check(sv_long == 0, {"R8 pulse width ", tag}, BLK'(sv_long), '0);
    endtask

    task automatic run_seed(input string tag);
        int c0 = ncap, a0 = ack_total, s0 = nseed;
        pulse_more();
        finish_seed(tag, c0, a0, s0, src_en & ~src_err);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (30) @(negedge clk);
        // R1
        check(ack_total == 0 && ncap == 0, "R1 no activity before request",
              BLK'(ack_total), '0);
        check(!seed_valid && seed_key == '0 && seed_block == '0, "R1 seed outputs zero",
              BLK'(seed_key), '0);
    endtask

    task automatic t_idle();
        int a0 = ack_total, c0 = ncap;
        logic [255:0] k0 = seed_key;
        repeat (100) @(negedge clk);
        // R9
        check(ack_total == a0 && ncap == c0, "R9 idle after seed", BLK'(ack_total), BLK'(a0));
        // R10
        check(seed_key == k0, "R10 seed held", BLK'(seed_key), BLK'(k0));
    endtask

    task automatic t_skip();
        src_en = 3'b101;
        run_seed("R3 disabled source 1");
        src_en = 3'b111; src_err = 3'b001;
        run_seed("R3 error on source 0");
        src_err = '0;
    endtask

    task automatic t_valid_stall();
        fork
            run_seed("R2 source 2 stalls");
            begin
                for (int i = 0; i < 200; i++) @(negedge clk) src_valid[2] = (i % 5) > 2;
                src_valid[2] = 1'b1;
            end
        join
    endtask

    task automatic t_hash_hold();
        int c0 = ncap, a0 = ack_total, s0 = nseed;
        hold_ready = 1'b1;
        pulse_more();
        repeat (150) @(negedge clk);
        // R6 R5: collection stops at a full block while the hash is not ready
        check(ack_total - a0 == BWD, "R6 stall on busy hash", BLK'(ack_total - a0), BLK'(BWD));
        check(ncap == c0, "R5 no start while not ready", BLK'(ncap), BLK'(c0));
        hold_ready = 1'b0;
        finish_seed("R5 after hold", c0, a0, s0, src_en & ~src_err);
    endtask

    task automatic t_more_ignored();
        int c0 = ncap, a0 = ack_total, s0 = nseed;
        pulse_more();
        repeat (10) @(negedge clk);
        pulse_more();
        // R9: second request mid-sequence must not restart
        finish_seed("R9 extra request", c0, a0, s0, src_en & ~src_err);
    endtask

    bit done = 1'b0;
    initial begin
        t_reset();
        run_seed("R2 all healthy");
        t_idle();
        t_skip();
        t_valid_stall();
        t_hash_hold();
        t_more_ignored();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule